// File: doc/BRIEF.md
# Seven-Slot Pixel Lane Serializer

This block takes one RGB pixel with ten bits per colour, the three timing bits (display enable, vertical sync, horizontal sync) and two spare bits, and spreads them over five data lanes of seven bits each. Each lane word is then sent one bit per bit-rate enable, so that one pixel period lasts seven enables. A sixth lane carries a fixed framing pattern that lets a receiver find word boundaries.

The pixel bus is captured into a holding register whenever the valid strobe is high. At the end of each seven-slot frame the serializer reloads all six shift registers from the held pixel, so frames run back to back without a bubble. An active-low power-down silences the outputs. The enable is modelled as a flag and the lanes are held low. Leaving power-down always restarts at the first slot of a frame. The bit-rate timing comes from a single-clock-domain enable, `bit_en`, which is pulsed at seven times the pixel rate.

Top module: `pixser_top`

## Requirements
- R1: While reset is applied and after it, until the first frame starts, `oe_o` is 0 and `lane_o` and `clk_lane_o` are 0.
- R2: Within a frame the slot sent first is slot 6, then slots 5 down to 0. The slot advances only on a clock with `bit_en` high, and the outputs hold steady on clocks where `bit_en` is low.
- R3: Lane A (`lane_o[0]`) sends, slot 6 down to slot 0: G[4], R[9], R[8], R[7], R[6], R[5], R[4].
- R4: Lane B (`lane_o[1]`) sends, slot 6 down to slot 0: B[5], B[4], G[9], G[8], G[7], G[6], G[5].
- R5: Lane C (`lane_o[2]`) sends, slot 6 down to slot 0: display enable, vertical sync, horizontal sync, B[9], B[8], B[7], B[6].
- R6: Lane D (`lane_o[3]`) sends `pix_aux[0]` then B[3], B[2], G[3], G[2], R[3], R[2]. Lane E (`lane_o[4]`) sends `pix_aux[1]` then B[1], B[0], G[1], G[0], R[1], R[0].
- R7: The clock lane sends the pattern 1,1,0,0,0,1,1 for slots 6 down to 0 in every frame.
- R8: The `bit_en` that follows slot 0 loads the next frame into all six lanes and sets slot 6, with no idle slot in between.
- R9: A pixel is captured on every clock with `pix_valid` high. A frame load uses the last pixel captured on an earlier clock. When no new pixel has arrived, the previous pixel is sent again.
- R10: A clock edge that samples `pd_n` low drops `oe_o` and forces every lane output to 0, whatever `bit_en` is.
- R11: After `pd_n` returns high, the first clock with `bit_en` high starts a complete frame at slot 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for all logic |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bit_en | input | 1 | Bit-slot enable, seven pulses per pixel period |
| pd_n | input | 1 | Active-low power-down |
| pix_valid | input | 1 | Pixel bus holds a new pixel this clock |
| pix_r | input | 10 | Red component |
| pix_g | input | 10 | Green component |
| pix_b | input | 10 | Blue component |
| pix_de | input | 1 | Display enable bit |
| pix_vs | input | 1 | Vertical sync bit |
| pix_hs | input | 1 | Horizontal sync bit |
| pix_aux | input | 2 | Spare bits: bit 0 to lane D, bit 1 to lane E |
| lane_o | output | 5 | Serial data lanes, bit 0 = lane A through bit 4 = lane E |
| clk_lane_o | output | 1 | Serial framing clock lane |
| oe_o | output | 1 | Output enable; low models the high-impedance state |

## Verification
The assertions assume that `pd_n`, `bit_en` and `pix_valid` are synchronous to `clk` and change only between edges. They also assume that `bit_en` alone sets the slot rate, with no minimum spacing between pulses. The stimulus drives every input on the falling edge. It mixes bursts with `bit_en` high on each clock with random gaps, short and long power-down pulses, and valid strobes that land on any slot, frame loads included. Reset is applied only at the start, with power-down held low until the internal reset release has passed.

// File: rtl/pixser_pkg.sv
package pixser_pkg;
  localparam int SLOTS  = 7;
  localparam int LANES  = 5;
  localparam int CW     = 10;
  localparam int AUX_W  = 2;
  localparam int SLOT_W = $clog2(SLOTS);
  localparam logic [SLOTS-1:0] CLK_PAT = 7'b1100011;

  typedef struct packed {
    logic [CW-1:0]    r;
    logic [CW-1:0]    g;
    logic [CW-1:0]    b;
    logic             de;
    logic             vs;
    logic             hs;
    logic [AUX_W-1:0] aux;
  } pixel_t;

  typedef logic [SLOTS-1:0] word_t;
endpackage

// File: rtl/pixser_pack.sv
module pixser_pack
  import pixser_pkg::*;
(
  input  pixel_t                 px,
  output logic [LANES-1:0][SLOTS-1:0] words
);
  // Slot 6 is the MSB of each word and leaves first.
  always_comb begin
    words[0] = {px.g[4], px.r[9:4]};
    words[1] = {px.b[5:4], px.g[9:5]};
    words[2] = {px.de, px.vs, px.hs, px.b[9:6]};
    words[3] = {px.aux[0], px.b[3:2], px.g[3:2], px.r[3:2]};
    words[4] = {px.aux[1], px.b[1:0], px.g[1:0], px.r[1:0]};
  end
endmodule

// File: rtl/pixser_sequencer.sv
module pixser_sequencer
  import pixser_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic              pd_n,
  output logic              load,
  output logic              shift,
  output logic              live,
  output logic [SLOT_W-1:0] slot
);
  localparam logic [SLOT_W-1:0] TOP = SLOT_W'(SLOTS - 1);

  logic              live_q, live_d;
  logic [SLOT_W-1:0] slot_q, slot_d;

  always_comb begin
    live_d = live_q;
    slot_d = slot_q;
    load   = 1'b0;
    shift  = 1'b0;
    if (!pd_n) begin
      live_d = 1'b0;
      slot_d = TOP;
    end else if (bit_en) begin
      if (!live_q || slot_q == '0) begin
        load   = 1'b1;
        live_d = 1'b1;
        slot_d = TOP;
      end else begin
        shift  = 1'b1;
        slot_d = slot_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q <= 1'b0;
      slot_q <= TOP;
    end else begin
      live_q <= live_d;
      slot_q <= slot_d;
    end
  end

  assign live = live_q;
  assign slot = slot_q;
endmodule

// File: rtl/pixser_shifter.sv
module pixser_shifter #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         shift,
  input  logic [W-1:0] din,
  output logic         msb
);
  logic [W-1:0] sh_q, sh_d;

  always_comb begin
    sh_d = sh_q;
    if (load)       sh_d = din;
    else if (shift) sh_d = {sh_q[W-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign msb = sh_q[W-1];
endmodule

// File: rtl/pixser_top.sv
module pixser_top
  import pixser_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic             pd_n,
  input  logic             pix_valid,
  input  logic [CW-1:0]    pix_r,
  input  logic [CW-1:0]    pix_g,
  input  logic [CW-1:0]    pix_b,
  input  logic             pix_de,
  input  logic             pix_vs,
  input  logic             pix_hs,
  input  logic [AUX_W-1:0] pix_aux,
  output logic [LANES-1:0] lane_o,
  output logic             clk_lane_o,
  output logic             oe_o
);
  // Reset: asserts at once, releases after two clocks.
  logic rst_meta, rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_q    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_q    <= rst_meta;
    end
  end

  // Holding register for the next pixel.
  pixel_t hold_q, hold_d;
  always_comb begin
    hold_d = hold_q;
    if (pix_valid)
      hold_d = '{r: pix_r, g: pix_g, b: pix_b, de: pix_de, vs: pix_vs,
                 hs: pix_hs, aux: pix_aux};
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) hold_q <= '0;
    else        hold_q <= hold_d;
  end

  logic              load, shift, live;
  logic [SLOT_W-1:0] slot_q;

  pixser_sequencer u_seq (
    .clk    (clk),
    .rst_n  (rst_q),
    .bit_en (bit_en),
    .pd_n   (pd_n),
    .load   (load),
    .shift  (shift),
    .live   (live),
    .slot   (slot_q)
  );

  logic [LANES-1:0][SLOTS-1:0] words;
  pixser_pack u_pack (
    .px    (hold_q),
    .words (words)
  );

  logic [LANES-1:0] lane_msb;
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    pixser_shifter #(.W(SLOTS)) u_sh (
      .clk   (clk),
      .rst_n (rst_q),
      .load  (load),
      .shift (shift),
      .din   (words[i]),
      .msb   (lane_msb[i])
    );
  end

  logic clk_msb;
  pixser_shifter #(.W(SLOTS)) u_clk_sh (
    .clk   (clk),
    .rst_n (rst_q),
    .load  (load),
    .shift (shift),
    .din   (CLK_PAT),
    .msb   (clk_msb)
  );

  assign lane_o     = lane_msb & {LANES{live}};
  assign clk_lane_o = clk_msb & live;
  assign oe_o       = live;
endmodule

// File: rtl/pixser_checker.sv
module pixser_checker
  import pixser_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              bit_en,
  input logic              pd_n,
  input logic [LANES-1:0]  lane_o,
  input logic              clk_lane_o,
  input logic              oe_o,
  input logic [SLOT_W-1:0] slot_q
);
  p_pd_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !pd_n |=> (!oe_o && lane_o == '0 && !clk_lane_o));

  p_oe_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(oe_o) |-> $past(!pd_n));

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_o && pd_n && !bit_en) |=> (oe_o && $stable(lane_o) && $stable(clk_lane_o)));

  p_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!oe_o && pd_n && bit_en) |=> (oe_o && slot_q == SLOT_W'(SLOTS - 1)));

  p_clk_pat_r7: assert property (@(posedge clk) disable iff (!rst_n)
    oe_o |-> (clk_lane_o == CLK_PAT[slot_q]));

  p_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_o && pd_n && bit_en && slot_q == '0) |=> (oe_o && slot_q == SLOT_W'(SLOTS - 1)));

  p_quiet_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_o |-> (lane_o == '0 && !clk_lane_o));
endmodule

bind pixser_top pixser_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_q),
  .bit_en     (bit_en),
  .pd_n       (pd_n),
  .lane_o     (lane_o),
  .clk_lane_o (clk_lane_o),
  .oe_o       (oe_o),
  .slot_q     (slot_q)
);

// File: tb/pixser_top_tb.sv
module pixser_top_tb;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n, bit_en, pd_n, pix_valid;
  logic [9:0] pr, pg, pb;
  logic       pde, pvs, phs;
  logic [1:0] paux;
  wire  [4:0] lane;
  wire        clk_lane, oe;

  pixser_top u_dut (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .pd_n(pd_n),
    .pix_valid(pix_valid), .pix_r(pr), .pix_g(pg), .pix_b(pb),
    .pix_de(pde), .pix_vs(pvs), .pix_hs(phs), .pix_aux(paux),
    .lane_o(lane), .clk_lane_o(clk_lane), .oe_o(oe)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  // Reference model state.
  logic        m_live;
  int          m_slot;
  logic [34:0] m_hold;
  logic [6:0]  m_w [5];
  logic [6:0]  cap_w [5];
  logic [6:0]  cap_c;
  localparam logic [6:0] CLKW = 7'b1100011;

  function automatic logic [6:0] lane_word(logic [34:0] p, int k);
    logic [9:0] r, g, b;
    r = p[34:25]; g = p[24:15]; b = p[14:5];
    case (k)
      0:       return {g[4], r[9:4]};
      1:       return {b[5:4], g[9:5]};
      2:       return {p[4], p[3], p[2], b[9:6]};
      3:       return {p[0], b[3:2], g[3:2], r[3:2]};
      default: return {p[1], b[1:0], g[1:0], r[1:0]};
    endcase
  endfunction

  function automatic logic [6:0] exp_out();
    logic [6:0] v;
    v = '0;
    if (m_live) begin
      for (int i = 0; i < 5; i++) v[i] = m_w[i][m_slot];
      v[5] = CLKW[m_slot];
      v[6] = 1'b1;
    end
    return v;
  endfunction

  task automatic check_eq(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic model_step();
    logic [34:0] old_hold;
    if (!rst_n) begin
      m_live = 0; m_slot = 6; m_hold = '0;
      for (int i = 0; i < 5; i++) m_w[i] = '0;
      return;
    end
    old_hold = m_hold;
    if (pix_valid) m_hold = {pr, pg, pb, pde, pvs, phs, paux};
    if (!pd_n) begin
      m_live = 0; m_slot = 6;
    end else if (bit_en) begin
      if (!m_live || m_slot == 0) begin
        for (int i = 0; i < 5; i++) m_w[i] = lane_word(old_hold, i);
        m_live = 1; m_slot = 6;
      end else begin
        m_slot = m_slot - 1;
      end
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    model_step();
    check_eq("R2/R8/R9/R10 stream", {25'd0, oe, clk_lane, lane}, {25'd0, exp_out()});
  endtask

  task automatic capture();
    for (int i = 0; i < 5; i++) cap_w[i] = '0;
    cap_c = '0;
    for (int s = 0; s < 7; s++) begin
      tick();
      for (int i = 0; i < 5; i++) cap_w[i] = {cap_w[i][5:0], lane[i]};
      cap_c = {cap_c[5:0], clk_lane};
    end
  endtask

  task automatic check_p1(string sfx);
    check_eq({"R3 lane A ", sfx}, {25'd0, cap_w[0]}, 32'h7F);
    check_eq({"R4 lane B ", sfx}, {25'd0, cap_w[1]}, 32'h00);
    check_eq({"R5 lane C ", sfx}, {25'd0, cap_w[2]}, 32'h50);
    check_eq({"R6 lane D ", sfx}, {25'd0, cap_w[3]}, 32'h00);
    check_eq({"R6 lane E ", sfx}, {25'd0, cap_w[4]}, 32'h40);
    check_eq({"R7 clock lane ", sfx}, {25'd0, cap_c}, 32'h63);
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R2 watchdog act=running exp=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [6:0]  snap;
    logic [34:0] p2;
    void'($urandom(32'd20240607));
    rst_n = 0; bit_en = 0; pd_n = 0; pix_valid = 0;
    pr = 0; pg = 0; pb = 0; pde = 0; pvs = 0; phs = 0; paux = 0;
    tick(); tick();
    check_eq("R1 reset outputs", {29'd0, oe, clk_lane, |lane}, 32'd0);
    rst_n = 1;
    repeat (4) tick();
    check_eq("R1 idle after reset", {29'd0, oe, clk_lane, |lane}, 32'd0);

    // Directed pixel: R=3F0, G=010, B=0, DE=1, VS=0, HS=1, aux=10.
    pr = 10'h3F0; pg = 10'h010; pb = 10'h000; pde = 1; pvs = 0; phs = 1; paux = 2'b10;
    pix_valid = 1;
    tick();
    pix_valid = 0; pd_n = 1; bit_en = 1;
    capture(); check_p1("first frame");
    capture(); check_p1("R8 R9 repeat frame");

    // R2: gap in bit_en freezes the outputs mid-frame.
    tick(); tick();
    bit_en = 0;
    snap = {oe, clk_lane, lane};
    repeat (3) tick();
    check_eq("R2 hold without bit_en", {25'd0, oe, clk_lane, lane}, {25'd0, snap});

    // R10: power-down mid-frame.
    bit_en = 1; pd_n = 0;
    tick();
    check_eq("R10 power-down quiet", {29'd0, oe, clk_lane, |lane}, 32'd0);
    tick();
    check_eq("R10 power-down with bit_en", {29'd0, oe, clk_lane, |lane}, 32'd0);

    // R11: release restarts at slot 6.
    pd_n = 1;
    capture(); check_p1("R11 restart");

    // R9: valid on the load edge goes to the frame after.
    p2 = {10'h2A5, 10'h15A, 10'h3C3, 1'b0, 1'b1, 1'b0, 2'b01};
    {pr, pg, pb, pde, pvs, phs, paux} = p2;
    pix_valid = 1;
    tick();
    pix_valid = 0;
    repeat (6) tick();
    capture();
    for (int i = 0; i < 5; i++)
      check_eq("R9 new pixel next frame", {25'd0, cap_w[i]}, {25'd0, lane_word(p2, i)});

    // Random phase.
    for (int n = 0; n < 6000; n++) begin
      bit_en    = (n % 1000 < 300) ? 1'b1 : ($urandom_range(0, 3) != 0);
      pd_n      = ($urandom_range(0, 99) < 3) ? 1'b0 : 1'b1;
      if (n % 1500 > 1480) pd_n = 0;
      pix_valid = ($urandom_range(0, 5) == 0);
      pr = 10'($urandom); pg = 10'($urandom); pb = 10'($urandom);
      pde = 1'($urandom); pvs = 1'($urandom); phs = 1'($urandom);
      paux = 2'($urandom);
      tick();
    end

    done = 1;
    summary();
    $finish;
  end
endmodule